// File: doc/BRIEF.md
# Multi-stage watchdog timer

This block holds one independent watchdog per processor core. Software programs each watchdog with a 16-bit length and an enable bit. The length becomes the upper bits of a 24-bit down counter, and the low 8 bits start at zero. The counter steps down once every `DIVISOR` clock cycles. A core shows that it is alive by pulsing its poke input. A poke reloads that core's counter and puts the watchdog back into its first stage.

If a core is not poked, its watchdog escalates one stage at each expiry. The first expiry sends a one-cycle interrupt pulse. The second expiry raises a non-maskable interrupt, which is held as a level. The third expiry sends a one-cycle soft-reset request and switches the watchdog off until it is programmed again. A read port returns the live count and the stage code of any core, one cycle after that core is selected.

Top module: `wdog_array`

## Requirements
- R1: A configuration write to core `cfg_sel` with `cfg_wdata[16]`=1 stores the length `cfg_wdata[15:0]`. It loads the counter with that length in bits 23:8 and zero in bits 7:0, and sets the stage to 0.
- R2: While enabled, the counter steps down once every `DIVISOR` cycles. An expiry happens on a step that finds the count at zero. The first expiry therefore comes `DIVISOR`*(count+1) cycles after the load.
- R3: At an expiry in stage 0, `irq_o` of that core pulses high for exactly one cycle, the stage becomes 1 and the counter reloads.
- R4: At an expiry in stage 1, the stage becomes 2 and the counter reloads. `nmi_o` stays high for as long as the stage is 2.
- R5: At an expiry in stage 2, `srst_req_o` pulses high for one cycle, the stage becomes 3, the count becomes 0 and the watchdog disables itself. Stage 3 is held until the next configuration write.
- R6: A poke to an enabled watchdog reloads the counter, sets the stage to 0 and restarts the step divider. A poke wins over an expiry in the same cycle.
- R7: A poke to a disabled watchdog has no effect on its count, its stage or its outputs.
- R8: A configuration write with `cfg_wdata[16]`=0 disables the watchdog. It clears the count and the stage to 0 and stops counting.
- R9: Each core has its own poke and its own outputs. A configuration write touches only the core named by `cfg_sel`.
- R10: `rd_count_o` and `rd_stage_o` show the count and the stage of core `rd_sel` as they were in the previous cycle. The stage codes are 0 counting, 1 interrupt, 2 NMI and 3 reset.
- R11: After reset, every watchdog is disabled with count 0 and stage 0, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Core addressed by the write |
| cfg_wdata | input | LEN_W+1 | Bit LEN_W is enable; bits LEN_W-1:0 are the length |
| poke_i | input | N_CORES | Per-core service pulse |
| rd_sel | input | SEL_W | Core whose state is read back |
| rd_count_o | output | LEN_W+LOW_W | Count of the selected core |
| rd_stage_o | output | 2 | Stage code of the selected core |
| irq_o | output | N_CORES | First-stage interrupt pulse |
| nmi_o | output | N_CORES | NMI level during the second stage |
| srst_req_o | output | N_CORES | Soft-reset request pulse |

## Verification
The assertions check on every cycle that:
- the interrupt and reset-request pulses last exactly one cycle;
- the three outputs of a core are never high together;
- an NMI starts only from stage 1;
- a reset request leaves the watchdog disabled;
- a poke to an enabled watchdog always returns it to stage 0, even when an expiry falls in the same cycle;
- a disabled watchdog keeps its stage.

The exact cycle counts of each period, the 8-bit shift of the length, the poke and expiry collision at a known cycle, and the readback latency can only be shown by the bench scenarios. In those scenarios a per-core reference model runs alongside random pokes and random configuration writes.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    ST_COUNT = 2'd0,
    ST_IRQ   = 2'd1,
    ST_NMI   = 2'd2,
    ST_RESET = 2'd3
  } wd_stage_e;
endpackage

// File: rtl/wdog_presc.sv
module wdog_presc #(
  parameter int DIV = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [PW-1:0] div_q;

  assign tick = run && (div_q == PW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      div_q <= '0;
    end else if (div_q == PW'(DIV - 1)) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int LOW_W = 8,
  parameter int DIV   = 256,
  localparam int CNT_W = LEN_W + LOW_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             load_en,
  input  logic [LEN_W-1:0] load_len,
  input  logic             poke,
  output logic             en_o,
  output wd_stage_e        stage_o,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o,
  output logic             nmi_o,
  output logic             srst_o
);
  logic             en_q, en_n;
  wd_stage_e        st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [LEN_W-1:0] len_q;
  logic             irq_q, irq_n, nmi_q, srst_q, srst_n;
  logic             tick, restart;
  logic [CNT_W-1:0] reload_val;

  assign restart    = load || (en_q && poke);
  assign reload_val = {len_q, {LOW_W{1'b0}}};

  wdog_presc #(.DIV(DIV)) presc_i (
    .clk     (clk),
    .rst     (rst),
    .run     (en_q),
    .restart (restart),
    .tick    (tick)
  );

  always_comb begin
    en_n   = en_q;
    st_n   = st_q;
    cnt_n  = cnt_q;
    irq_n  = 1'b0;
    srst_n = 1'b0;
    if (load) begin
      st_n = ST_COUNT;
      if (load_en) begin
        en_n  = 1'b1;
        cnt_n = {load_len, {LOW_W{1'b0}}};
      end else begin
        en_n  = 1'b0;
        cnt_n = '0;
      end
    end else if (en_q && poke) begin
      st_n  = ST_COUNT;
      cnt_n = reload_val;
    end else if (en_q && tick) begin
      if (cnt_q == '0) begin
        unique case (st_q)
          ST_COUNT: begin
            st_n  = ST_IRQ;
            irq_n = 1'b1;
            cnt_n = reload_val;
          end
          ST_IRQ: begin
            st_n  = ST_NMI;
            cnt_n = reload_val;
          end
          ST_NMI: begin
            st_n   = ST_RESET;
            srst_n = 1'b1;
            en_n   = 1'b0;
            cnt_n  = '0;
          end
          default: en_n = 1'b0;
        endcase
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      st_q   <= ST_COUNT;
      cnt_q  <= '0;
      len_q  <= '0;
      irq_q  <= 1'b0;
      nmi_q  <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      en_q   <= en_n;
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      irq_q  <= irq_n;
      nmi_q  <= (st_n == ST_NMI);
      srst_q <= srst_n;
      if (load && load_en) len_q <= load_len;
    end
  end

  assign en_o    = en_q;
  assign stage_o = st_q;
  assign count_o = cnt_q;
  assign irq_o   = irq_q;
  assign nmi_o   = nmi_q;
  assign srst_o  = srst_q;
endmodule

// File: rtl/wdog_rdmux.sv
module wdog_rdmux #(
  parameter int N_CORES = 4,
  parameter int CNT_W   = 24,
  parameter int SEL_W   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SEL_W-1:0]     sel,
  input  logic [CNT_W-1:0]     cnt_arr [N_CORES],
  input  logic [2*N_CORES-1:0] stage_vec,
  output logic [CNT_W-1:0]     count_o,
  output logic [1:0]           stage_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count_o <= '0;
      stage_o <= '0;
    end else if (int'(sel) < N_CORES) begin
      count_o <= cnt_arr[sel];
      stage_o <= stage_vec[2*sel +: 2];
    end else begin
      count_o <= '0;
      stage_o <= '0;
    end
  end
endmodule

// File: rtl/wdog_array.sv
module wdog_array
  import wdog_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int LEN_W   = 16,
  parameter int LOW_W   = 8,
  parameter int DIVISOR = 256,
  localparam int SEL_W  = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int CNT_W  = LEN_W + LOW_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [LEN_W:0]     cfg_wdata,
  input  logic [N_CORES-1:0] poke_i,
  input  logic [SEL_W-1:0]   rd_sel,
  output logic [CNT_W-1:0]   rd_count_o,
  output logic [1:0]         rd_stage_o,
  output logic [N_CORES-1:0] irq_o,
  output logic [N_CORES-1:0] nmi_o,
  output logic [N_CORES-1:0] srst_req_o
);
  logic [CNT_W-1:0]     cnt_arr [N_CORES];
  logic [2*N_CORES-1:0] stage_vec;
  logic [N_CORES-1:0]   en_vec;

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    wd_stage_e st;
    wdog_core #(.LEN_W(LEN_W), .LOW_W(LOW_W), .DIV(DIVISOR)) core_i (
      .clk      (clk),
      .rst      (rst),
      .load     (cfg_we && (cfg_sel == SEL_W'(c))),
      .load_en  (cfg_wdata[LEN_W]),
      .load_len (cfg_wdata[LEN_W-1:0]),
      .poke     (poke_i[c]),
      .en_o     (en_vec[c]),
      .stage_o  (st),
      .count_o  (cnt_arr[c]),
      .irq_o    (irq_o[c]),
      .nmi_o    (nmi_o[c]),
      .srst_o   (srst_req_o[c])
    );
    assign stage_vec[2*c +: 2] = st;
  end

  wdog_rdmux #(.N_CORES(N_CORES), .CNT_W(CNT_W), .SEL_W(SEL_W)) rdmux_i (
    .clk       (clk),
    .rst       (rst),
    .sel       (rd_sel),
    .cnt_arr   (cnt_arr),
    .stage_vec (stage_vec),
    .count_o   (rd_count_o),
    .stage_o   (rd_stage_o)
  );
endmodule

// File: rtl/wdog_array_chk.sv
module wdog_array_chk #(
  parameter int N_CORES = 4,
  parameter int SEL_W   = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cfg_we,
  input logic [SEL_W-1:0]     cfg_sel,
  input logic [N_CORES-1:0]   poke_i,
  input logic [N_CORES-1:0]   irq_o,
  input logic [N_CORES-1:0]   nmi_o,
  input logic [N_CORES-1:0]   srst_req_o,
  input logic [N_CORES-1:0]   en_vec,
  input logic [2*N_CORES-1:0] stage_vec
);
  for (genvar c = 0; c < N_CORES; c++) begin : g_chk
    logic hit;
    assign hit = cfg_we && (cfg_sel == SEL_W'(c));

    // R3
    irq_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      irq_o[c] |=> !irq_o[c]);

    // R5
    srst_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      srst_req_o[c] |=> !srst_req_o[c]);

    // R5
    srst_disables_chk: assert property (@(posedge clk) disable iff (rst)
      srst_req_o[c] |-> (!en_vec[c] && stage_vec[2*c +: 2] == 2'd3));

    // R4
    nmi_from_irq_stage_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(nmi_o[c]) |-> ($past(stage_vec[2*c +: 2]) == 2'd1));

    // R9
    outputs_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({irq_o[c], nmi_o[c], srst_req_o[c]}));

    // R6
    poke_restarts_chk: assert property (@(posedge clk) disable iff (rst)
      (poke_i[c] && en_vec[c] && !hit) |=>
        (stage_vec[2*c +: 2] == 2'd0 && !irq_o[c] && !srst_req_o[c]));

    // R7
    disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!en_vec[c] && !hit) |=> $stable(stage_vec[2*c +: 2]));
  end
endmodule

bind wdog_array wdog_array_chk #(.N_CORES(N_CORES), .SEL_W(SEL_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .cfg_we     (cfg_we),
  .cfg_sel    (cfg_sel),
  .poke_i     (poke_i),
  .irq_o      (irq_o),
  .nmi_o      (nmi_o),
  .srst_req_o (srst_req_o),
  .en_vec     (en_vec),
  .stage_vec  (stage_vec)
);

// File: tb/wdog_array_tb_top.sv
`timescale 1ns/1ps
module wdog_array_tb_top;
  localparam int N   = 4;
  localparam int DIV = 4;
  localparam int SW  = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [SW-1:0] cfg_sel = '0;
  logic [16:0]   cfg_wdata = '0;
  logic [N-1:0]  poke_i = '0;
  logic [SW-1:0] rd_sel = '0;
  logic [23:0]   rd_count_o;
  logic [1:0]    rd_stage_o;
  logic [N-1:0]  irq_o, nmi_o, srst_req_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  bit cmp_on = 0;

  always #5 clk = ~clk;

  wdog_array #(.N_CORES(N), .DIVISOR(DIV)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .poke_i(poke_i), .rd_sel(rd_sel), .rd_count_o(rd_count_o), .rd_stage_o(rd_stage_o),
    .irq_o(irq_o), .nmi_o(nmi_o), .srst_req_o(srst_req_o)
  );

  // reference model, built from the requirements
  bit m_en [N];
  int m_cnt [N];
  int m_pre [N];
  int m_st [N];
  int m_len [N];
  logic [N-1:0] e_irq = '0, e_nmi = '0, e_srst = '0;
  int e_rdc = 0, e_rds = 0;

  function automatic int full_count(int len);
    return len * 256; // R1: length in bits 23:8, zeros below
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      for (int c = 0; c < N; c++) begin
        m_en[c] = 0; m_cnt[c] = 0; m_pre[c] = 0; m_st[c] = 0; m_len[c] = 0;
      end
      e_irq = '0; e_nmi = '0; e_srst = '0; e_rdc = 0; e_rds = 0;
    end else begin
      e_rdc = m_cnt[rd_sel];
      e_rds = m_st[rd_sel];
      for (int c = 0; c < N; c++) begin
        e_irq[c] = 1'b0;
        e_srst[c] = 1'b0;
        if (cfg_we && int'(cfg_sel) == c) begin
          m_pre[c] = 0; m_st[c] = 0;
          if (cfg_wdata[16]) begin
            m_en[c] = 1; m_len[c] = int'(cfg_wdata[15:0]); m_cnt[c] = full_count(m_len[c]);
          end else begin
            m_en[c] = 0; m_cnt[c] = 0;
          end
        end else if (m_en[c] && poke_i[c]) begin
          m_cnt[c] = full_count(m_len[c]); m_st[c] = 0; m_pre[c] = 0;
        end else if (m_en[c]) begin
          if (m_pre[c] == DIV - 1) begin
            m_pre[c] = 0;
            if (m_cnt[c] == 0) begin
              case (m_st[c])
                0: begin m_st[c] = 1; e_irq[c] = 1'b1; m_cnt[c] = full_count(m_len[c]); end
                1: begin m_st[c] = 2; m_cnt[c] = full_count(m_len[c]); end
                default: begin m_st[c] = 3; e_srst[c] = 1'b1; m_en[c] = 0; m_cnt[c] = 0; end
              endcase
            end else begin
              m_cnt[c] = m_cnt[c] - 1;
            end
          end else begin
            m_pre[c] = m_pre[c] + 1;
          end
        end
        e_nmi[c] = (m_st[c] == 2);
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      for (int c = 0; c < N; c++) begin
        check($sformatf("R3 irq core %0d", c), int'(irq_o[c]), int'(e_irq[c]));
        check($sformatf("R4 nmi core %0d", c), int'(nmi_o[c]), int'(e_nmi[c]));
        check($sformatf("R5 srst core %0d", c), int'(srst_req_o[c]), int'(e_srst[c]));
      end
      check("R10 rd_count", int'(rd_count_o), e_rdc);
      check("R10 rd_stage", int'(rd_stage_o), e_rds);
    end
  end

  task automatic cfg_write(int core, bit en, int len);
    cfg_we = 1'b1; cfg_sel = SW'(core); cfg_wdata = {en, 16'(len)};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin : watchdog
    wait (cyc > 190000);
    errors++;
    $display("FAIL watchdog expired actual %0d expected below 190000", cyc);
    finish_run();
  end

  initial begin : stim
    int k;
    void'($urandom(32'h5eed_2024));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    check("R11 irq", int'(irq_o), 0);
    check("R11 nmi", int'(nmi_o), 0);
    check("R11 srst", int'(srst_req_o), 0);
    check("R11 rd_count", int'(rd_count_o), 0);
    check("R11 rd_stage", int'(rd_stage_o), 0);
    cmp_on = 1;

    // Directed: full escalation on core 0, length 1
    rd_sel = 0;
    cfg_write(0, 1'b1, 1);        // k = 1 already consumed by the write task
    k = 1;
    @(negedge clk); k++;
    check("R1 loaded count", int'(rd_count_o), 256);
    check("R1 loaded stage", int'(rd_stage_o), 0);
    while (!irq_o[0] && k < 5000) begin @(negedge clk); k++; end
    check("R2 cycles to first expiry", k, DIV * 257 + 1);
    check("R9 other cores quiet", int'(irq_o[3:1]), 0);
    k = 0;
    while (!nmi_o[0] && k < 5000) begin @(negedge clk); k++; end
    check("R4 cycles to nmi", k, DIV * 257);
    k = 0;
    while (!srst_req_o[0] && k < 5000) begin @(negedge clk); k++; end
    check("R5 cycles to reset request", k, DIV * 257);
    @(negedge clk);
    check("R5 nmi dropped", int'(nmi_o[0]), 0);
    check("R5 stage held at 3", int'(rd_stage_o), 3);
    poke_i[0] = 1'b1;
    @(negedge clk);
    poke_i[0] = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 poke while disabled, stage", int'(rd_stage_o), 3);
    check("R7 poke while disabled, count", int'(rd_count_o), 0);

    // Directed: poke coincides with expiry on core 1, length 0
    rd_sel = 1;
    cfg_write(1, 1'b1, 0);
    k = 1;
    while (k < 4) begin @(negedge clk); k++; end
    poke_i[1] = 1'b1;             // sampled on the expiry edge
    @(negedge clk); k++;
    poke_i[1] = 1'b0;
    check("R6 poke wins over expiry", int'(irq_o[1]), 0);
    @(negedge clk);
    check("R6 stage after poke", int'(rd_stage_o), 0);
    cfg_write(1, 1'b0, 0);
    repeat (3) @(negedge clk);
    check("R8 disabled count", int'(rd_count_o), 0);
    check("R8 disabled stage", int'(rd_stage_o), 0);
    check("R8 outputs low", int'({irq_o[1], nmi_o[1], srst_req_o[1]}), 0);

    // Random: pokes, writes and readback selection against the model
    for (int i = 0; i < 120000; i++) begin
      rd_sel = SW'($urandom_range(N - 1));
      for (int c = 0; c < N; c++) poke_i[c] = ($urandom_range(1499) == 0);
      if ($urandom_range(799) == 0) begin
        cfg_we = 1'b1;
        cfg_sel = SW'($urandom_range(N - 1));
        cfg_wdata = {($urandom_range(3) != 0), 16'($urandom_range(3))};
      end else begin
        cfg_we = 1'b0;
      end
      @(negedge clk);
    end
    cfg_we = 1'b0;
    poke_i = '0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule